// File: doc/BRIEF.md
# Input Level Error Integrator

This block measures how far the level of an incoming sample stream sits from a target, so that an automatic gain control loop can act on it. On every clock where a sample is presented, the block takes the sample's magnitude and adds it to a programmable signed threshold. It then adds that term to an accumulator. The threshold is normally negative, so the accumulated sum is a level error: it is positive when the signal is too strong and negative when it is too weak.

A configuration write sets three things: the threshold, the interval length in units of four samples, and the end-of-interval behaviour. A separate start strobe clears the accumulator and starts the interval. At the end of the interval the completed sum is copied into a result register and a valid flag is raised. The flag stays up until the processor acknowledges the result with a read strobe. In one-shot mode the block then goes idle. In continuous mode it begins the next interval straight away, with no lost sample.

Top module: `lvl_err_integrator`

## Requirements
- R1: After reset, `result` is zero, `result_valid` is 0 and `busy` is 0.
- R2: A sample's magnitude is the absolute value of its 14-bit two's-complement code. The code -8192 saturates to a magnitude of 8191.
- R3: While `busy` is high, each clock with `smp_valid` high adds (threshold + magnitude) to the running sum. A sample that is held for several clocks is counted once per clock.
- R4: A programmed length value P of 2 or more gives an interval of N = 4*(P-1) samples. The sum is captured on the clock of the N-th counted sample, and not before.
- R5: In one-shot mode (`cfg_cont` = 0), at the end of the interval the sum is captured, `result_valid` rises and `busy` falls. Samples presented after that change neither `result` nor `busy`.
- R6: In continuous mode (`cfg_cont` = 1), at the end of the interval the sum is captured and `busy` stays high. The next sample is the first term of a fresh interval that starts from zero.
- R7: A start strobe clears the running sum and reloads the interval, which throws away any partial sum. A sample presented in the same clock as a start strobe is not counted.
- R8: A start strobe while P is 0 or 1 captures a result of zero on the next clock, raises `result_valid` and leaves `busy` low.
- R9: `result_valid` stays high until a `rd_strobe` arrives. If a read strobe arrives in the same clock as a capture, the flag stays high. `result` changes only when a sum is captured.
- R10: The length value is sampled when an interval is loaded. A start strobe in the same clock as a configuration write uses the length that was registered before that write.
- R11: `result` is CNT_W+SMP_W+1 bits wide (33 by default) and signed. A negative sum appears sign-extended across the full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_cont | input | 1 | Mode: 0 one-shot, 1 continuous |
| cfg_len | input | CNT_W-2 | Interval length value P = N/4 + 1 |
| cfg_thr | input | SMP_W | Signed threshold |
| start_wr | input | 1 | Start / restart strobe |
| smp_valid | input | 1 | Sample present this clock |
| smp_data | input | SMP_W | Two's-complement sample |
| rd_strobe | input | 1 | Processor read acknowledge |
| result | output | CNT_W+SMP_W+1 | Captured signed sum |
| result_valid | output | 1 | Captured sum not yet read |
| busy | output | 1 | Interval in progress |

## Verification
The hardest situation to reach is the boundary of a continuous run. The capture, the accumulator reload and the first term of the next interval all meet within two clocks. Each sample code can also only be checked through a sum.

The stimulus streams every one of the 16384 sample codes back to back through 1024-sample continuous intervals. Each captured sum is compared with an arithmetic total computed in the bench. Short one-shot runs then cover saturation, held samples, restarts, a read that coincides with a capture, and a configuration write that lands in the same clock as a start strobe.

// File: rtl/lvl_pkg.sv
package lvl_pkg;
    typedef enum logic {
        MODE_ONESHOT = 1'b0,
        MODE_CONT    = 1'b1
    } lvl_mode_e;
endpackage

// File: rtl/lvl_abs.sv
// Saturating absolute value of a two's-complement sample.
module lvl_abs #(
    parameter int W = 14
) (
    input  logic signed [W-1:0] x,
    output logic        [W-2:0] mag
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        if (x == MOST_NEG) begin
            mag = '1;
        end else if (x[W-1]) begin
            mag = ~x[W-2:0] + 1'b1;
        end else begin
            mag = x[W-2:0];
        end
    end
endmodule

// File: rtl/lvl_term.sv
// Threshold plus magnitude, widened by one bit so it cannot wrap.
module lvl_term #(
    parameter int W = 14
) (
    input  logic signed [W-1:0] thr,
    input  logic        [W-2:0] mag,
    output logic signed [W:0]   term
);
    always_comb begin
        term = $signed({thr[W-1], thr}) + $signed({2'b00, mag});
    end
endmodule

// File: rtl/lvl_span_ctr.sv
// Down-counter for the interval, in samples. Load has priority over step.
module lvl_span_ctr #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic             expire,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (step && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire = step && (cnt_q == CNT_W'(1));
    assign count  = cnt_q;
endmodule

// File: rtl/lvl_err_integrator.sv
module lvl_err_integrator
    import lvl_pkg::*;
#(
    parameter int SMP_W = 14,
    parameter int CNT_W = 18,
    localparam int LEN_W  = CNT_W - 2,
    localparam int TERM_W = SMP_W + 1,
    localparam int ACC_W  = CNT_W + TERM_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic                    cfg_cont,
    input  logic [LEN_W-1:0]        cfg_len,
    input  logic signed [SMP_W-1:0] cfg_thr,
    input  logic                    start_wr,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_data,
    input  logic                    rd_strobe,
    output logic signed [ACC_W-1:0] result,
    output logic                    result_valid,
    output logic                    busy
);
    typedef struct packed {
        logic                    busy;
        lvl_mode_e               mode;
        logic [LEN_W-1:0]        len;
        logic signed [SMP_W-1:0] thr;
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] res;
        logic                    vld;
    } st_t;

    st_t st_d, st_q;

    logic [SMP_W-2:0]        mag;
    logic signed [TERM_W-1:0] term;
    logic signed [ACC_W-1:0] acc_sum;
    logic [CNT_W-1:0]        span_len;
    logic                    step;
    logic                    ctr_load;
    logic                    ctr_expire;
    logic [CNT_W-1:0]        ctr_cnt;
    logic                    cap_w;
    logic signed [ACC_W-1:0] acc_now;
    logic                    mode_now;

    lvl_abs #(.W(SMP_W)) u_abs (
        .x   (smp_data),
        .mag (mag)
    );

    lvl_term #(.W(SMP_W)) u_term (
        .thr  (st_q.thr),
        .mag  (mag),
        .term (term)
    );

    lvl_span_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (span_len),
        .step     (step),
        .expire   (ctr_expire),
        .count    (ctr_cnt)
    );

    // Interval in samples: 4*(P-1), or zero when P is 0 or 1.
    always_comb begin
        if (st_q.len <= LEN_W'(1)) begin
            span_len = '0;
        end else begin
            span_len = {st_q.len - LEN_W'(1), 2'b00};
        end
    end

    assign step    = st_q.busy && smp_valid && !start_wr;
    assign acc_sum = st_q.acc + {{(ACC_W-TERM_W){term[TERM_W-1]}}, term};

    always_comb begin
        st_d     = st_q;
        ctr_load = 1'b0;
        cap_w    = 1'b0;

        if (cfg_wr) begin
            st_d.mode = lvl_mode_e'(cfg_cont);
            st_d.len  = cfg_len;
            st_d.thr  = cfg_thr;
        end

        if (start_wr) begin
            st_d.acc = '0;
            if (span_len == '0) begin
                st_d.busy = 1'b0;
                st_d.res  = '0;
                cap_w     = 1'b1;
            end else begin
                st_d.busy = 1'b1;
                ctr_load  = 1'b1;
            end
        end else if (step) begin
            st_d.acc = acc_sum;
            if (ctr_expire) begin
                cap_w    = 1'b1;
                st_d.res = acc_sum;
                if (st_q.mode == MODE_CONT && span_len != '0) begin
                    st_d.acc = '0;
                    ctr_load = 1'b1;
                end else begin
                    st_d.busy = 1'b0;
                end
            end
        end

        if (cap_w) begin
            st_d.vld = 1'b1;
        end else if (rd_strobe) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_now      = st_q.acc;
    assign mode_now     = st_q.mode;
    assign result       = st_q.res;
    assign result_valid = st_q.vld;
    assign busy         = st_q.busy;
endmodule

// File: rtl/lvl_integrator_chk.sv
module lvl_integrator_chk #(
    parameter int CNT_W = 18,
    parameter int ACC_W = 33
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_wr,
    input logic                    rd_strobe,
    input logic signed [ACC_W-1:0] result,
    input logic                    result_valid,
    input logic                    busy,
    input logic                    cap,
    input logic [CNT_W-1:0]        cnt,
    input logic signed [ACC_W-1:0] acc,
    input logic                    expire,
    input logic                    cont_mode
);
    p_count_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> cnt != '0);

    p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !start_wr && !cont_mode) |=> !busy);

    p_idle_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_wr) |=> $stable(acc));

    p_valid_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !rd_strobe) |=> result_valid);

    p_read_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !cap) |=> !result_valid);

    p_result_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(result));
endmodule

bind lvl_err_integrator lvl_integrator_chk #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_wr     (start_wr),
    .rd_strobe    (rd_strobe),
    .result       (result),
    .result_valid (result_valid),
    .busy         (busy),
    .cap          (cap_w),
    .cnt          (ctr_cnt),
    .acc          (acc_now),
    .expire       (ctr_expire),
    .cont_mode    (mode_now)
);

// File: tb/lvl_err_integrator_test.sv
module lvl_err_integrator_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic cfg_cont = 1'b0;
    logic [15:0] cfg_len = '0;
    logic signed [13:0] cfg_thr = '0;
    logic start_wr = 1'b0;
    logic smp_valid = 1'b0;
    logic signed [13:0] smp_data = '0;
    logic rd_strobe = 1'b0;
    logic signed [32:0] result;
    logic result_valid;
    logic busy;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lvl_err_integrator uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_cont(cfg_cont),
        .cfg_len(cfg_len), .cfg_thr(cfg_thr), .start_wr(start_wr),
        .smp_valid(smp_valid), .smp_data(smp_data), .rd_strobe(rd_strobe),
        .result(result), .result_valid(result_valid), .busy(busy)
    );

    function automatic longint absat(input int x);
        if (x == -8192) return 8191;
        return (x < 0) ? -x : x;
    endfunction

    task automatic chk(input string tag, input longint got, input longint exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Drive one clock of inputs; returns at the next falling edge.
    task automatic cyc(input logic v, input int x, input logic st,
                       input logic rd, input logic cw);
        smp_valid = v; smp_data = 14'(x); start_wr = st;
        rd_strobe = rd; cfg_wr = cw;
        @(negedge clk);
        smp_valid = 0; start_wr = 0; rd_strobe = 0; cfg_wr = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got hung expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        longint exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 result", longint'(result), 0);
        chk("R1 valid", longint'(result_valid), 0);
        chk("R1 busy", longint'(busy), 0);

        // R2 R3 R4 R6: sweep every sample code through continuous 1024-sample intervals
        cfg_cont = 1; cfg_len = 16'd257; cfg_thr = -14'sd100;
        cyc(0, 0, 0, 0, 1);
        cyc(0, 0, 1, 0, 0);
        for (int k = 0; k < 16; k++) begin
            exp = 0;
            for (int i = 0; i < 1024; i++) begin
                int x;
                x = -8192 + k * 1024 + i;
                exp += -100 + absat(x);
                cyc(1, x, 0, (i == 0 && k > 0), 0);
            end
            chk("R6 valid at interval end", longint'(result_valid), 1);
            chk("R2 R3 interval sum", longint'(result), exp);
        end
        chk("R6 busy continues", longint'(busy), 1);

        // R10: config write with start in same clock keeps old length (1024)
        cfg_cont = 0; cfg_len = 16'd2; cfg_thr = 14'sd5;
        cyc(0, 0, 1, 1, 1);
        for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 0);
        chk("R10 old length used", longint'(result_valid), 0);
        chk("R10 still busy", longint'(busy), 1);

        // R4 R5 R3: one-shot, N=4, held sample counted twice, saturation
        cyc(0, 0, 1, 0, 0);
        cyc(1, 7, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        cyc(1, -8192, 0, 0, 0);
        cyc(1, -8192, 0, 0, 0);
        chk("R4 no early capture", longint'(result_valid), 0);
        cyc(1, -3, 0, 0, 0);
        chk("R5 valid", longint'(result_valid), 1);
        chk("R3 R2 one-shot sum", longint'(result), 20 + 7 + 8191 + 8191 + 3);
        chk("R5 busy falls", longint'(busy), 0);
        for (int i = 0; i < 3; i++) cyc(1, 100, 0, 0, 0);
        chk("R5 result held", longint'(result), 20 + 7 + 8191 + 8191 + 3);
        chk("R5 stays idle", longint'(busy), 0);
        chk("R9 valid held", longint'(result_valid), 1);
        cyc(0, 0, 0, 1, 0);
        chk("R9 read clears", longint'(result_valid), 0);

        // R9: read in same clock as capture
        cyc(0, 0, 1, 0, 0);
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0);
        cyc(1, 0, 0, 1, 0);
        chk("R9 capture beats read", longint'(result_valid), 1);
        chk("R9 result", longint'(result), 20);
        cyc(0, 0, 0, 1, 0);

        // R7: restart discards partial sum and coincident sample
        cyc(0, 0, 1, 0, 0);
        cyc(1, 50, 0, 0, 0);
        cyc(1, 50, 0, 0, 0);
        cyc(1, 1000, 1, 0, 0);
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0);
        chk("R7 no capture yet", longint'(result_valid), 0);
        cyc(1, 0, 0, 0, 0);
        chk("R7 restart sum", longint'(result), 20);

        // R8: zero-length intervals
        cfg_len = 16'd1;
        cyc(0, 0, 0, 1, 1);
        cyc(0, 0, 1, 0, 0);
        chk("R8 P=1 valid", longint'(result_valid), 1);
        chk("R8 P=1 result", longint'(result), 0);
        chk("R8 P=1 busy", longint'(busy), 0);
        cfg_len = 16'd0;
        cyc(0, 0, 0, 1, 1);
        cyc(0, 0, 1, 0, 0);
        chk("R8 P=0 valid", longint'(result_valid), 1);
        chk("R8 P=0 busy", longint'(busy), 0);

        // R11: negative sum sign-extended
        cfg_len = 16'd2; cfg_thr = -14'sd8192;
        cyc(0, 0, 0, 1, 1);
        cyc(0, 0, 1, 0, 0);
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0);
        chk("R11 negative sum", longint'(result), -32768);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule